// File: doc/BRIEF.md
# Three-Button Sequence Lock Controller

This block watches three push-button lines and drives a single release output for an electrically held door lock. A fixed three-step code opens the lock: button 1, then button 2, then button 3. Each accepted press is compared with the button expected at the current position. A matching press moves the entry forward by one step. Any other press throws the entry away. When the third step completes, the release output is driven high for a fixed five-second window. It then drops, and the lock re-engages without any further action.

Raw button lines are asynchronous and active low. A pressed button pulls its line to 0, and an idle button is held at 1 by a pull-up. Each line is resynchronised first. Simultaneous presses are then reduced to a single button code by a fixed priority. After an accepted press, a 300 ms hold-off window starts, and all inputs are ignored until it ends; this window absorbs switch bounce. Both the hold-off window and the open window are cycle counts derived from a clock-frequency parameter, so a bench can shrink them.

Two observation pins support checking. A 2-bit progress count shows the steps entered so far. A one-cycle flag marks every rejected press. The interface has no data stream, so every pin is plain control or status and no valid/ready handshake applies.

Top module: `seq_lock_ctrl`

## Requirements
- R1: After reset, `release_o` is 0, `step_o` is 0 and `reject_o` is 0.
- R2: `key_n_i[0]` is button 1, `key_n_i[1]` is button 2 and `key_n_i[2]` is button 3. A line at 0 means pressed. Each line passes through a two-flop synchroniser. A press driven before rising edge k is reflected on `step_o` or `reject_o` after rising edge k+2.
- R3: When several lines are low in the same cycle, button 1 wins over button 2, and button 2 wins over button 3. One accepted press yields exactly one button code and at most one step.
- R4: The expected button is step+1: button 1 at step 0, button 2 at step 1 and button 3 at step 2. A matching accepted press increments `step_o`.
- R5: An accepted press that does not match the expected button sets `step_o` to 0 and raises `reject_o` for exactly one cycle. That press does not count as a first step, even when it is button 1.
- R6: After any accepted press, every input is ignored for HOLD_CYC = CLK_HZ*300/1000 cycles. A button still held when the window ends is accepted again as a new press.
- R7: The accepted third step raises `release_o` for exactly OPEN_CYC = CLK_HZ*5 cycles, and `step_o` reads 3 throughout. `release_o` then falls, and `step_o` returns to 0 on the same edge.
- R8: While `release_o` is high, presses are neither accepted nor rejected. They do not change `step_o` and do not raise `reject_o`.
- R9: With all lines idle, `step_o`, `release_o` and `reject_o` hold their values indefinitely.
- R10: The parameter CLK_HZ (default 24_000_000) is the only timing input. HOLD_CYC and OPEN_CYC are derived from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_n_i | input | 3 | Raw button lines, active low, bit 0 = button 1 |
| release_o | output | 1 | High while the lock is held open |
| step_o | output | 2 | Number of correct steps entered (3 while open) |
| reject_o | output | 1 | One-cycle flag on every rejected press |

## Verification
The assertions assume that the button lines are idle-high, that they change at most once in a few cycles, and that CLK_HZ gives HOLD_CYC of at least 2 and OPEN_CYC longer than HOLD_CYC. The bench uses CLK_HZ = 1000, which gives HOLD_CYC = 300 and OPEN_CYC = 5000. It changes the lines only on falling clock edges. It holds each press for tens of cycles and releases the line before the hold-off window closes. The one exception is the scenario that keeps a button held on purpose to exercise the repeat rule.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;
  localparam int unsigned NUM_KEYS = 3;

  typedef enum logic [1:0] {
    KEY_NONE = 2'd0,
    KEY_ONE  = 2'd1,
    KEY_TWO  = 2'd2,
    KEY_THREE = 2'd3
  } key_e;

  // cycles in a window of 'ms' milliseconds, never less than one
  function automatic longint unsigned ms_cycles(longint unsigned hz, longint unsigned ms);
    longint unsigned c;
    c = (hz * ms) / 64'd1000;
    return (c == 64'd0) ? 64'd1 : c;
  endfunction
endpackage

// File: rtl/seq_lock_sync.sv
module seq_lock_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_n_i,
  output logic [WIDTH-1:0] sync_n_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // stages reset to idle (all ones) so no press appears out of reset
  generate
    for (genvar s = 0; s < int'(STAGES); s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= raw_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_n_o = stage_q[STAGES-1];
endmodule

// File: rtl/seq_lock_arb.sv
module seq_lock_arb
  import seq_lock_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 300
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] pressed_i,
  input  logic                busy_i,
  output logic                take_o,
  output key_e                key_o
);
  localparam int unsigned HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC - 1);

  logic [HW-1:0] hold_q;
  logic          window_open;

  assign window_open = (hold_q == '0);
  assign take_o      = window_open && (|pressed_i) && !busy_i;

  // lowest index wins: scan from the top so the last hit is the winner
  always_comb begin
    key_o = KEY_NONE;
    for (int i = NUM_KEYS - 1; i >= 0; i--) begin
      if (pressed_i[i]) key_o = key_e'(2'(i + 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_q <= '0;
    else if (take_o)     hold_q <= HOLD_LOAD;
    else if (!window_open) hold_q <= hold_q - 1'b1;
  end

  a_r3_one_code: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (key_o != KEY_NONE));
  a_r3_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && pressed_i[0]) |-> (key_o == KEY_ONE));
  a_r6_holdoff_gap: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !take_o);
endmodule

// File: rtl/seq_lock_track.sv
module seq_lock_track
  import seq_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_i,
  input  key_e       key_i,
  input  logic       expire_i,
  output logic [1:0] step_o,
  output logic       reject_o,
  output logic       open_req_o
);
  logic [1:0] step_q;
  logic       reject_q;
  logic       match;
  key_e       want;

  assign want       = key_e'(2'(step_q + 2'd1));
  assign match      = take_i && (key_i == want);
  assign open_req_o = match && (step_q == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= 2'd0;
      reject_q <= 1'b0;
    end else begin
      reject_q <= take_i && !match;
      if (expire_i)     step_q <= 2'd0;
      else if (match)   step_q <= step_q + 2'd1;
      else if (take_i)  step_q <= 2'd0;
    end
  end

  assign step_o   = step_q;
  assign reject_o = reject_q;

  a_r5_reject_clears: assert property (@(posedge clk) disable iff (!rst_n)
    reject_q |-> (step_q == 2'd0));
  a_r5_reject_single: assert property (@(posedge clk) disable iff (!rst_n)
    reject_q |=> !reject_q);
  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !expire_i) |=> (step_q == $past(step_q) + 2'd1));
endmodule

// File: rtl/seq_lock_timer.sv
module seq_lock_timer #(
  parameter int unsigned OPEN_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o,
  output logic expire_o
);
  localparam int unsigned TW = (OPEN_CYC < 2) ? 1 : $clog2(OPEN_CYC);
  localparam logic [TW-1:0] OPEN_LOAD = TW'(OPEN_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic          active_q;

  assign expire_o = active_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= OPEN_LOAD;
    end else if (expire_o) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> !start_i);
  a_r7_holds_open: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != '0) |=> active_q);
endmodule

// File: rtl/seq_lock_ctrl.sv
module seq_lock_ctrl
  import seq_lock_pkg::*;
#(
  parameter int unsigned CLK_HZ = 24_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] key_n_i,
  output logic       release_o,
  output logic [1:0] step_o,
  output logic       reject_o
);
  // R10: both windows derive from the clock rate alone
  localparam int unsigned HOLD_CYC = int'(ms_cycles(64'(CLK_HZ), 64'd300));
  localparam int unsigned OPEN_CYC = int'(ms_cycles(64'(CLK_HZ), 64'd5000));

  logic [NUM_KEYS-1:0] key_sync_n;
  logic                take;
  key_e                key_code;
  logic                open_req;
  logic                expire;
  logic                open_now;

  seq_lock_sync #(.WIDTH(NUM_KEYS), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_n_i  (key_n_i),
    .sync_n_o (key_sync_n)
  );

  seq_lock_arb #(.HOLD_CYC(HOLD_CYC)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pressed_i (~key_sync_n),
    .busy_i    (open_now),
    .take_o    (take),
    .key_o     (key_code)
  );

  seq_lock_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .key_i      (key_code),
    .expire_i   (expire),
    .step_o     (step_o),
    .reject_o   (reject_o),
    .open_req_o (open_req)
  );

  seq_lock_timer #(.OPEN_CYC(OPEN_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (open_req),
    .active_o (open_now),
    .expire_o (expire)
  );

  assign release_o = open_now;

  a_r7_open_shows_three: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> (step_o == 2'd3));
  a_r7_relock_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(release_o) |-> (step_o == 2'd0));
  a_r7_open_after_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(release_o) |-> ($past(step_o) == 2'd2));
  a_r8_no_reject_open: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> !reject_o);
endmodule

// File: tb/seq_lock_ctrl_bench.sv
module seq_lock_ctrl_bench;
  localparam int unsigned HZ   = 1000;
  localparam int          HOLD = 300;
  localparam int          OPEN = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] key_n = 3'b111;
  logic       release_o;
  logic [1:0] step;
  logic       reject;

  int n_checks = 0;
  int n_fails  = 0;
  int rejects  = 0;
  int open_len = 0;
  int last_open_len = 0;
  bit done = 1'b0;

  seq_lock_ctrl #(.CLK_HZ(HZ)) u_seq_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .key_n_i(key_n),
    .release_o(release_o), .step_o(step), .reject_o(reject)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (reject) rejects++;
    if (release_o) open_len++;
    else if (open_len != 0) begin
      last_open_len = open_len;
      open_len = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  // press the buttons in mask, hold, release, then wait out the hold-off
  task automatic press(input logic [2:0] mask, input int hold);
    @(negedge clk);
    key_n = ~mask;
    repeat (hold) @(negedge clk);
    key_n = 3'b111;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic wait_relock();
    for (int i = 0; i < OPEN + 50 && release_o; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(release_o == 1'b0, "R1 release", int'(release_o), 0);
    chk(step == 2'd0, "R1 step", int'(step), 0);
    chk(reject == 1'b0, "R1 reject", int'(reject), 0);
  endtask

  task automatic t_latency();
    int n;
    n = 0;
    @(negedge clk);
    key_n = 3'b110;
    while (step != 2'd1 && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == 3, "R2 latency to step", n, 3);
    repeat (17) @(negedge clk);
    key_n = 3'b111;
    repeat (HOLD) @(negedge clk);
    chk(step == 2'd1, "R2 step after button 1", int'(step), 1);
    press(3'b100, 20);
    chk(step == 2'd0, "R2 reset via button 3", int'(step), 0);
  endtask

  task automatic t_open_sequence();
    int r0;
    r0 = rejects;
    press(3'b001, 20);
    chk(step == 2'd1, "R4 step one", int'(step), 1);
    press(3'b010, 20);
    chk(step == 2'd2, "R4 step two", int'(step), 2);
    repeat (1000) @(negedge clk);
    chk(step == 2'd2, "R9 idle holds step", int'(step), 2);
    chk(release_o == 1'b0, "R9 idle stays locked", int'(release_o), 0);
    press(3'b100, 20);
    chk(release_o == 1'b1, "R7 release high", int'(release_o), 1);
    chk(step == 2'd3, "R7 step reads three", int'(step), 3);
    wait_relock();
    chk(last_open_len == OPEN, "R7 open length", last_open_len, OPEN);
    chk(step == 2'd0, "R7 step cleared", int'(step), 0);
    chk(rejects == r0, "R4 no rejects", rejects - r0, 0);
  endtask

  task automatic t_wrong_first();
    int r0;
    r0 = rejects;
    press(3'b010, 20);
    chk(step == 2'd0, "R5 wrong at start", int'(step), 0);
    chk(rejects == r0 + 1, "R5 one reject pulse", rejects - r0, 1);
  endtask

  task automatic t_wrong_not_counted();
    int r0;
    r0 = rejects;
    press(3'b001, 20);
    press(3'b001, 20);
    chk(step == 2'd0, "R5 repeat button 1 not a first step", int'(step), 0);
    chk(rejects == r0 + 1, "R5 reject on repeat", rejects - r0, 1);
  endtask

  task automatic t_priority();
    int r0;
    r0 = rejects;
    press(3'b011, 20);
    chk(step == 2'd1, "R3 button 1 over 2", int'(step), 1);
    press(3'b110, 20);
    chk(step == 2'd2, "R3 button 2 over 3", int'(step), 2);
    press(3'b101, 20);
    chk(step == 2'd0, "R3 button 1 over 3 rejected", int'(step), 0);
    chk(rejects == r0 + 1, "R3 single code per press", rejects - r0, 1);
  endtask

  task automatic t_holdoff_ignore();
    int r0;
    r0 = rejects;
    @(negedge clk);
    key_n = 3'b110;
    repeat (20) @(negedge clk);
    key_n = 3'b111;
    repeat (80) @(negedge clk);
    key_n = 3'b011;
    repeat (20) @(negedge clk);
    key_n = 3'b111;
    repeat (HOLD) @(negedge clk);
    chk(step == 2'd1, "R6 press in hold-off ignored", int'(step), 1);
    chk(rejects == r0, "R6 no reject in hold-off", rejects - r0, 0);
    press(3'b100, 20);
    chk(step == 2'd0, "R6 back to zero", int'(step), 0);
  endtask

  task automatic t_holdoff_repeat();
    int t1, t2, cyc;
    t1 = -1; t2 = -1; cyc = 0;
    @(negedge clk);
    key_n = 3'b110;
    for (int i = 0; i < HOLD + 100; i++) begin
      @(negedge clk);
      cyc++;
      if (t1 < 0 && step == 2'd1) t1 = cyc;
      if (t2 < 0 && reject) t2 = cyc;
    end
    key_n = 3'b111;
    repeat (HOLD) @(negedge clk);
    chk(t1 >= 0 && t2 >= 0, "R6 held button accepted twice", t2, 1);
    chk(t2 - t1 == HOLD, "R6 hold-off length", t2 - t1, HOLD);
    chk(step == 2'd0, "R6 repeat rejected", int'(step), 0);
  endtask

  task automatic t_ignore_open();
    int r0;
    press(3'b001, 20);
    press(3'b010, 20);
    press(3'b100, 20);
    r0 = rejects;
    press(3'b001, 20);
    press(3'b100, 20);
    chk(release_o == 1'b1, "R8 still open", int'(release_o), 1);
    chk(step == 2'd3, "R8 step unchanged", int'(step), 3);
    chk(rejects == r0, "R8 no rejects while open", rejects - r0, 0);
    wait_relock();
    chk(last_open_len == OPEN, "R8 open length unaffected", last_open_len, OPEN);
    chk(step == 2'd0, "R8 step zero after relock", int'(step), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (500) @(negedge clk);
    t_reset();
    t_latency();
    t_open_sequence();
    t_wrong_first();
    t_wrong_not_counted();
    t_priority();
    t_holdoff_ignore();
    t_holdoff_repeat();
    t_ignore_open();
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end
endmodule